// File: doc/BRIEF.md
# Sensor Frame Timing Generator

This block sequences the readout of an image sensor. It counts master clocks across each row and counts rows across each frame. It drives a frame-valid level over the active rows and a line-valid level over the active columns of each row. It also emits a single-cycle pulse at the start of every row and another at the start of every frame. Two full sets of geometry and exposure settings are present at the inputs, and a select line chooses which set governs the next frame.

The row period is the window width plus the horizontal blanking. Two rules can raise the blanking. Each column binning mode sets its own lower limit on the blanking, and the row period as a whole can never be shorter than 704 clocks. After the active rows comes the vertical blanking interval. The programmed value for that interval is a number of rows. When the coarse plus fine exposure would not fit inside the readout, the interval is stretched internally and the register input is left alone. The blanking actually applied is reported at the outputs.

Every setting is sampled once, at the boundary between frames. A frame that is already running keeps the values it started with.

Top module: `ftg_frame_timer`

## Requirements
- R1: The row period in clocks is the window width plus the effective horizontal blanking. The spacing between consecutive frame-start pulses equals height × row period + effective vertical blanking in clocks.
- R2: The effective horizontal blanking is at least the floor set by the binning mode: 61 for `bin_mode` 2'b00 (normal), 71 for 2'b01 (bin 2), and 91 for 2'b10 or 2'b11 (bin 4). A programmed value above the floor is used as given.
- R3: When width plus clamped blanking is below 704, the blanking is raised to 704 − width, which makes the row period exactly 704.
- R4: `frame_valid` is high for exactly height × row period consecutive cycles per frame. It is low during vertical blanking and while reset is asserted.
- R5: `line_valid` is high only inside the active rows, and only for the first `width` clocks of each row.
- R6: `row_start` pulses in the first clock of every active row. `frame_start` pulses in the first clock of the first row, and it always coincides with a `row_start`.
- R7: Without extension, the effective vertical blanking in clocks is vblank × row period + 4.
- R8: When coarse + 2 exceeds height, the extended length (coarse + 2 − height) × row period + fine + 4 is computed. The effective vertical blanking is the larger of this value and the R7 value.
- R9: `eff_hblank` and `eff_vblank` report the blanking in use for the current frame. The programmed inputs are never altered.
- R10: `ctx_sel` = 0 selects the A settings and `ctx_sel` = 1 selects the B settings, for all six fields.
- R11: Changes to `ctx_sel`, `bin_mode` or any setting input take effect only at the next frame start. `eff_hblank` and `eff_vblank` stay stable throughout a frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctx_sel | input | 1 | Context select, 0 = A, 1 = B |
| bin_mode | input | 2 | Column binning mode |
| a_width | input | WIN_W | Context A window width |
| a_height | input | HGT_W | Context A window height (rows, nonzero) |
| a_hblank | input | HB_W | Context A horizontal blanking |
| a_vblank | input | VB_W | Context A vertical blanking (rows) |
| a_coarse | input | SHUT_W | Context A coarse shutter total (rows) |
| a_fine | input | FINE_W | Context A fine shutter total (clocks) |
| b_width | input | WIN_W | Context B window width |
| b_height | input | HGT_W | Context B window height (rows, nonzero) |
| b_hblank | input | HB_W | Context B horizontal blanking |
| b_vblank | input | VB_W | Context B vertical blanking (rows) |
| b_coarse | input | SHUT_W | Context B coarse shutter total (rows) |
| b_fine | input | FINE_W | Context B fine shutter total (clocks) |
| frame_valid | output | 1 | High over active rows |
| line_valid | output | 1 | High over active columns |
| frame_start | output | 1 | Pulse at first clock of a frame |
| row_start | output | 1 | Pulse at first clock of each active row |
| eff_hblank | output | HB_W | Horizontal blanking in use |
| eff_vblank | output | CLK_W | Vertical blanking in use, clocks |

## Verification
On every cycle, the assertions check the following: line-valid stays inside frame-valid, frame-start coincides with row-start, no two row starts are adjacent, the row period never falls below the floor, the applied blanking meets the floor for the latched binning mode, and the reported blanking holds steady within a frame. The actual arithmetic cannot be checked by the assertions, because they have no view of the intended settings. Only the bench scenarios can show these results: the padding to 704 clocks, the choice between the normal and the stretched vertical blanking (including the case where the two are equal), which context was picked, and the deferral of a change made in the middle of a frame.

// File: rtl/ftg_pkg.sv
package ftg_pkg;

  typedef enum logic [1:0] {
    BIN_NONE = 2'b00,
    BIN_TWO  = 2'b01,
    BIN_FOUR = 2'b10,
    BIN_RSVD = 2'b11
  } bin_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'b00,
    ST_ACTIVE = 2'b01,
    ST_VBLANK = 2'b10
  } seq_state_e;

  localparam int unsigned ROW_FLOOR  = 704;
  localparam int unsigned HB_FL_NONE = 61;
  localparam int unsigned HB_FL_TWO  = 71;
  localparam int unsigned HB_FL_FOUR = 91;
  localparam int unsigned VB_TAIL    = 4;

  function automatic int unsigned hb_floor(input logic [1:0] mode);
    case (bin_mode_e'(mode))
      BIN_NONE: hb_floor = HB_FL_NONE;
      BIN_TWO:  hb_floor = HB_FL_TWO;
      default:  hb_floor = HB_FL_FOUR;
    endcase
  endfunction

endpackage

// File: rtl/ftg_ctx_shadow.sv
module ftg_ctx_shadow #(
  parameter int WIN_W  = 10,
  parameter int HGT_W  = 10,
  parameter int HB_W   = 10,
  parameter int VB_W   = 12,
  parameter int SHUT_W = 12,
  parameter int FINE_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              ctx_sel,
  input  logic [1:0]        bin_mode,
  input  logic [WIN_W-1:0]  a_width,
  input  logic [HGT_W-1:0]  a_height,
  input  logic [HB_W-1:0]   a_hblank,
  input  logic [VB_W-1:0]   a_vblank,
  input  logic [SHUT_W-1:0] a_coarse,
  input  logic [FINE_W-1:0] a_fine,
  input  logic [WIN_W-1:0]  b_width,
  input  logic [HGT_W-1:0]  b_height,
  input  logic [HB_W-1:0]   b_hblank,
  input  logic [VB_W-1:0]   b_vblank,
  input  logic [SHUT_W-1:0] b_coarse,
  input  logic [FINE_W-1:0] b_fine,
  output logic [1:0]        shd_bin,
  output logic [WIN_W-1:0]  shd_width,
  output logic [HGT_W-1:0]  shd_height,
  output logic [HB_W-1:0]   shd_hblank,
  output logic [VB_W-1:0]   shd_vblank,
  output logic [SHUT_W-1:0] shd_coarse,
  output logic [FINE_W-1:0] shd_fine
);

  logic [1:0]        bin_d;
  logic [WIN_W-1:0]  width_d;
  logic [HGT_W-1:0]  height_d;
  logic [HB_W-1:0]   hblank_d;
  logic [VB_W-1:0]   vblank_d;
  logic [SHUT_W-1:0] coarse_d;
  logic [FINE_W-1:0] fine_d;

  always_comb begin
    bin_d = bin_mode;
    if (ctx_sel) begin
      width_d  = b_width;
      height_d = b_height;
      hblank_d = b_hblank;
      vblank_d = b_vblank;
      coarse_d = b_coarse;
      fine_d   = b_fine;
    end else begin
      width_d  = a_width;
      height_d = a_height;
      hblank_d = a_hblank;
      vblank_d = a_vblank;
      coarse_d = a_coarse;
      fine_d   = a_fine;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shd_bin    <= '0;
      shd_width  <= '0;
      shd_height <= '0;
      shd_hblank <= '0;
      shd_vblank <= '0;
      shd_coarse <= '0;
      shd_fine   <= '0;
    end else if (load) begin
      shd_bin    <= bin_d;
      shd_width  <= width_d;
      shd_height <= height_d;
      shd_hblank <= hblank_d;
      shd_vblank <= vblank_d;
      shd_coarse <= coarse_d;
      shd_fine   <= fine_d;
    end
  end

endmodule

// File: rtl/ftg_row_calc.sv
module ftg_row_calc #(
  parameter int WIN_W = 10,
  parameter int HB_W  = 10,
  parameter int ROW_W = 11
) (
  input  logic [WIN_W-1:0] width,
  input  logic [HB_W-1:0]  hblank,
  input  logic [1:0]       bin,
  output logic [HB_W-1:0]  hb_eff,
  output logic [ROW_W-1:0] row_clks
);

  import ftg_pkg::*;

  logic [HB_W-1:0]  floor_hb;
  logic [HB_W-1:0]  hb_clamped;
  logic [ROW_W-1:0] floor_row;
  logic [ROW_W-1:0] width_ext;
  logic [ROW_W-1:0] sum_clamped;
  logic [ROW_W-1:0] pad_hb;

  always_comb begin
    floor_hb    = HB_W'(hb_floor(bin));
    floor_row   = ROW_W'(ROW_FLOOR);
    width_ext   = ROW_W'(width);
    hb_clamped  = (hblank < floor_hb) ? floor_hb : hblank;
    sum_clamped = width_ext + ROW_W'(hb_clamped);
    pad_hb      = floor_row - width_ext;
    if (sum_clamped < floor_row) begin
      hb_eff   = HB_W'(pad_hb);
      row_clks = floor_row;
    end else begin
      hb_eff   = hb_clamped;
      row_clks = sum_clamped;
    end
  end

endmodule

// File: rtl/ftg_vblank_calc.sv
module ftg_vblank_calc #(
  parameter int HGT_W  = 10,
  parameter int VB_W   = 12,
  parameter int SHUT_W = 12,
  parameter int FINE_W = 10,
  parameter int ROW_W  = 11,
  parameter int CLK_W  = 25
) (
  input  logic [ROW_W-1:0]  row_clks,
  input  logic [HGT_W-1:0]  height,
  input  logic [VB_W-1:0]   vblank,
  input  logic [SHUT_W-1:0] coarse,
  input  logic [FINE_W-1:0] fine,
  output logic [CLK_W-1:0]  vb_clks
);

  import ftg_pkg::*;

  logic [CLK_W-1:0] row_ext;
  logic [CLK_W-1:0] norm_clks;
  logic [CLK_W-1:0] span_rows;
  logic [CLK_W-1:0] hgt_rows;
  logic [CLK_W-1:0] long_clks;

  always_comb begin
    row_ext   = CLK_W'(row_clks);
    norm_clks = CLK_W'(vblank) * row_ext + CLK_W'(VB_TAIL);
    span_rows = CLK_W'(coarse) + CLK_W'(2);
    hgt_rows  = CLK_W'(height);
    if (span_rows > hgt_rows) begin
      long_clks = (span_rows - hgt_rows) * row_ext + CLK_W'(fine) + CLK_W'(VB_TAIL);
    end else begin
      long_clks = '0;
    end
    vb_clks = (long_clks > norm_clks) ? long_clks : norm_clks;
  end

endmodule

// File: rtl/ftg_seq_counter.sv
module ftg_seq_counter #(
  parameter int ROW_W = 11,
  parameter int HGT_W = 10,
  parameter int CLK_W = 25
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [ROW_W-1:0] width,
  input  logic [ROW_W-1:0] row_clks,
  input  logic [HGT_W-1:0] height,
  input  logic [CLK_W-1:0] vb_clks,
  output logic             load,
  output logic             frame_valid,
  output logic             line_valid,
  output logic             frame_start,
  output logic             row_start
);

  import ftg_pkg::*;

  seq_state_e       state_q, state_d;
  logic [ROW_W-1:0] col_q, col_d;
  logic [HGT_W-1:0] row_q, row_d;
  logic [CLK_W-1:0] vb_q, vb_d;
  logic             active;

  always_comb begin
    state_d = state_q;
    col_d   = col_q;
    row_d   = row_q;
    vb_d    = vb_q;
    load    = 1'b0;
    case (state_q)
      ST_IDLE: begin
        load    = 1'b1;
        state_d = ST_ACTIVE;
        col_d   = '0;
        row_d   = '0;
      end
      ST_ACTIVE: begin
        if (col_q == row_clks - ROW_W'(1)) begin
          col_d = '0;
          if (row_q == height - HGT_W'(1)) begin
            state_d = ST_VBLANK;
            vb_d    = '0;
          end else begin
            row_d = row_q + HGT_W'(1);
          end
        end else begin
          col_d = col_q + ROW_W'(1);
        end
      end
      ST_VBLANK: begin
        if (vb_q == vb_clks - CLK_W'(1)) begin
          load    = 1'b1;
          state_d = ST_ACTIVE;
          col_d   = '0;
          row_d   = '0;
        end else begin
          vb_d = vb_q + CLK_W'(1);
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      col_q   <= '0;
      row_q   <= '0;
      vb_q    <= '0;
    end else begin
      state_q <= state_d;
      col_q   <= col_d;
      row_q   <= row_d;
      vb_q    <= vb_d;
    end
  end

  always_comb begin
    active      = (state_q == ST_ACTIVE);
    frame_valid = active;
    line_valid  = active && (col_q < width);
    row_start   = active && (col_q == '0);
    frame_start = row_start && (row_q == '0);
  end

endmodule

// File: rtl/ftg_frame_timer.sv
module ftg_frame_timer #(
  parameter int WIN_W  = 10,
  parameter int HGT_W  = 10,
  parameter int HB_W   = 10,
  parameter int VB_W   = 12,
  parameter int SHUT_W = 12,
  parameter int FINE_W = 10,
  localparam int ROW_W = ((WIN_W > HB_W) ? WIN_W : HB_W) + 1,
  localparam int CLK_W = ROW_W + ((VB_W > SHUT_W) ? VB_W : SHUT_W) + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctx_sel,
  input  logic [1:0]        bin_mode,
  input  logic [WIN_W-1:0]  a_width,
  input  logic [HGT_W-1:0]  a_height,
  input  logic [HB_W-1:0]   a_hblank,
  input  logic [VB_W-1:0]   a_vblank,
  input  logic [SHUT_W-1:0] a_coarse,
  input  logic [FINE_W-1:0] a_fine,
  input  logic [WIN_W-1:0]  b_width,
  input  logic [HGT_W-1:0]  b_height,
  input  logic [HB_W-1:0]   b_hblank,
  input  logic [VB_W-1:0]   b_vblank,
  input  logic [SHUT_W-1:0] b_coarse,
  input  logic [FINE_W-1:0] b_fine,
  output logic              frame_valid,
  output logic              line_valid,
  output logic              frame_start,
  output logic              row_start,
  output logic [HB_W-1:0]   eff_hblank,
  output logic [CLK_W-1:0]  eff_vblank
);

  logic              load;
  logic [1:0]        shd_bin;
  logic [WIN_W-1:0]  shd_width;
  logic [HGT_W-1:0]  shd_height;
  logic [HB_W-1:0]   shd_hblank;
  logic [VB_W-1:0]   shd_vblank;
  logic [SHUT_W-1:0] shd_coarse;
  logic [FINE_W-1:0] shd_fine;
  logic [HB_W-1:0]   hb_eff;
  logic [ROW_W-1:0]  row_clks;
  logic [CLK_W-1:0]  vb_clks;

  ftg_ctx_shadow #(
    .WIN_W(WIN_W), .HGT_W(HGT_W), .HB_W(HB_W),
    .VB_W(VB_W), .SHUT_W(SHUT_W), .FINE_W(FINE_W)
  ) u_shadow (
    .clk(clk), .rst_n(rst_n), .load(load),
    .ctx_sel(ctx_sel), .bin_mode(bin_mode),
    .a_width(a_width), .a_height(a_height), .a_hblank(a_hblank),
    .a_vblank(a_vblank), .a_coarse(a_coarse), .a_fine(a_fine),
    .b_width(b_width), .b_height(b_height), .b_hblank(b_hblank),
    .b_vblank(b_vblank), .b_coarse(b_coarse), .b_fine(b_fine),
    .shd_bin(shd_bin), .shd_width(shd_width), .shd_height(shd_height),
    .shd_hblank(shd_hblank), .shd_vblank(shd_vblank),
    .shd_coarse(shd_coarse), .shd_fine(shd_fine)
  );

  ftg_row_calc #(
    .WIN_W(WIN_W), .HB_W(HB_W), .ROW_W(ROW_W)
  ) u_row (
    .width(shd_width), .hblank(shd_hblank), .bin(shd_bin),
    .hb_eff(hb_eff), .row_clks(row_clks)
  );

  ftg_vblank_calc #(
    .HGT_W(HGT_W), .VB_W(VB_W), .SHUT_W(SHUT_W),
    .FINE_W(FINE_W), .ROW_W(ROW_W), .CLK_W(CLK_W)
  ) u_vblank (
    .row_clks(row_clks), .height(shd_height), .vblank(shd_vblank),
    .coarse(shd_coarse), .fine(shd_fine), .vb_clks(vb_clks)
  );

  ftg_seq_counter #(
    .ROW_W(ROW_W), .HGT_W(HGT_W), .CLK_W(CLK_W)
  ) u_seq (
    .clk(clk), .rst_n(rst_n),
    .width(ROW_W'(shd_width)), .row_clks(row_clks),
    .height(shd_height), .vb_clks(vb_clks),
    .load(load), .frame_valid(frame_valid), .line_valid(line_valid),
    .frame_start(frame_start), .row_start(row_start)
  );

  assign eff_hblank = hb_eff;
  assign eff_vblank = vb_clks;

endmodule

// File: rtl/ftg_frame_timer_chk.sv
module ftg_frame_timer_chk #(
  parameter int HB_W  = 10,
  parameter int ROW_W = 11,
  parameter int CLK_W = 25
) (
  input logic             clk,
  input logic             rst_n,
  input logic             frame_valid,
  input logic             line_valid,
  input logic             frame_start,
  input logic             row_start,
  input logic [HB_W-1:0]  eff_hblank,
  input logic [CLK_W-1:0] eff_vblank,
  input logic [ROW_W-1:0] row_clks,
  input logic [1:0]       shd_bin
);

  assert_lv_inside_fv_R5: assert property (@(posedge clk) disable iff (!rst_n)
    line_valid |-> frame_valid);

  assert_fs_with_rs_R6: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |-> row_start);

  assert_rs_not_adjacent_R6: assert property (@(posedge clk) disable iff (!rst_n)
    row_start |=> !row_start);

  assert_row_floor_R3: assert property (@(posedge clk) disable iff (!rst_n)
    frame_valid |-> (row_clks >= ROW_W'(ftg_pkg::ROW_FLOOR)));

  assert_hb_mode_floor_R2: assert property (@(posedge clk) disable iff (!rst_n)
    frame_valid |-> (eff_hblank >= HB_W'(ftg_pkg::hb_floor(shd_bin))));

  assert_blank_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_valid && !frame_start) |-> ($stable(eff_hblank) && $stable(eff_vblank)));

endmodule

bind ftg_frame_timer ftg_frame_timer_chk #(
  .HB_W(HB_W), .ROW_W(ROW_W), .CLK_W(CLK_W)
) u_chk (
  .clk(clk), .rst_n(rst_n),
  .frame_valid(frame_valid), .line_valid(line_valid),
  .frame_start(frame_start), .row_start(row_start),
  .eff_hblank(eff_hblank), .eff_vblank(eff_vblank),
  .row_clks(row_clks), .shd_bin(shd_bin)
);

// File: tb/ftg_frame_timer_tb.sv
module ftg_frame_timer_tb;

  localparam int CLK_PERIOD = 10;
  localparam int WIN_W  = 10;
  localparam int HGT_W  = 10;
  localparam int HB_W   = 10;
  localparam int VB_W   = 12;
  localparam int SHUT_W = 12;
  localparam int FINE_W = 10;
  localparam int CLK_W  = 25;
  localparam int WATCHDOG = 150000;

  logic              clk;
  logic              rst_n;
  logic              ctx_sel;
  logic [1:0]        bin_mode;
  logic [WIN_W-1:0]  a_width,  b_width;
  logic [HGT_W-1:0]  a_height, b_height;
  logic [HB_W-1:0]   a_hblank, b_hblank;
  logic [VB_W-1:0]   a_vblank, b_vblank;
  logic [SHUT_W-1:0] a_coarse, b_coarse;
  logic [FINE_W-1:0] a_fine,   b_fine;
  logic              frame_valid, line_valid, frame_start, row_start;
  logic [HB_W-1:0]   eff_hblank;
  logic [CLK_W-1:0]  eff_vblank;

  ftg_frame_timer u_dut (
    .clk(clk), .rst_n(rst_n), .ctx_sel(ctx_sel), .bin_mode(bin_mode),
    .a_width(a_width), .a_height(a_height), .a_hblank(a_hblank),
    .a_vblank(a_vblank), .a_coarse(a_coarse), .a_fine(a_fine),
    .b_width(b_width), .b_height(b_height), .b_hblank(b_hblank),
    .b_vblank(b_vblank), .b_coarse(b_coarse), .b_fine(b_fine),
    .frame_valid(frame_valid), .line_valid(line_valid),
    .frame_start(frame_start), .row_start(row_start),
    .eff_hblank(eff_hblank), .eff_vblank(eff_vblank)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  int n_checks = 0;
  int n_fail   = 0;
  int cycles   = 0;
  bit done     = 0;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  // Behavioural reference: a frame is a time index t running from 0 to L-1
  bit     m_idle = 1;
  longint m_t, m_W, m_H, m_row, m_hb, m_vb, m_L;
  longint gap_exp = -1;
  longint gap_cnt = 0;
  bit     gap_armed = 0;

  task automatic capture();
    longint w, hbp, h, vbr, co, fi, fl, vbn, vbl;
    if (ctx_sel) begin
      w = b_width; hbp = b_hblank; h = b_height; vbr = b_vblank; co = b_coarse; fi = b_fine;
    end else begin
      w = a_width; hbp = a_hblank; h = a_height; vbr = a_vblank; co = a_coarse; fi = a_fine;
    end
    fl = (bin_mode == 2'b00) ? 61 : (bin_mode == 2'b01) ? 71 : 91;
    m_hb = (hbp < fl) ? fl : hbp;
    if (w + m_hb < 704) m_hb = 704 - w;
    m_W   = w;
    m_H   = h;
    m_row = w + m_hb;
    vbn   = vbr * m_row + 4;
    vbl   = (co + 2 > h) ? (co + 2 - h) * m_row + fi + 4 : 0;
    m_vb  = (vbl > vbn) ? vbl : vbn;
    m_L   = m_H * m_row + m_vb;
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_idle = 1;
    end else if (m_idle) begin
      capture();
      m_t = 0;
      m_idle = 0;
    end else if (m_t == m_L - 1) begin
      capture();
      m_t = 0;
    end else begin
      m_t = m_t + 1;
    end
  end

  always @(negedge clk) begin
    if (!rst_n) begin
      check(!frame_valid && !line_valid, "R4 reset fv/lv", {frame_valid, line_valid}, 0);
      check(!frame_start && !row_start, "R6 reset pulses", {frame_start, row_start}, 0);
    end else if (!m_idle) begin
      bit e_fv, e_lv, e_rs, e_fs;
      e_fv = (m_t < m_H * m_row);
      e_lv = e_fv && ((m_t % m_row) < m_W);
      e_rs = e_fv && ((m_t % m_row) == 0);
      e_fs = (m_t == 0);
      check(frame_valid == e_fv, "R4 frame_valid", frame_valid, e_fv);
      check(line_valid  == e_lv, "R5 line_valid", line_valid, e_lv);
      check(row_start   == e_rs, "R6 row_start", row_start, e_rs);
      check(frame_start == e_fs, "R6 frame_start", frame_start, e_fs);
      check(eff_hblank  == m_hb, "R2/R3 eff_hblank", eff_hblank, m_hb);
      check(eff_vblank  == m_vb, "R7/R8 eff_vblank", eff_vblank, m_vb);
      // R1: spacing between frame starts equals the previous frame length
      if (frame_start) begin
        if (gap_armed) check(gap_cnt == gap_exp, "R1 frame period", gap_cnt, gap_exp);
        gap_armed = 1;
        gap_exp = m_L;
        gap_cnt = 1;
      end else begin
        gap_cnt++;
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG && !done) begin
      done = 1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired after %0d cycles", cycles);
      finish_run();
    end
  end

  task automatic wait_fs();
    do @(negedge clk); while (!frame_start);
  endtask

  initial begin
    rst_n = 1'b0; ctx_sel = 1'b0; bin_mode = 2'b00;
    a_width = 100; a_hblank = 50; a_height = 3; a_vblank = 2; a_coarse = 1; a_fine = 0;
    b_width = 660; b_hblank = 20; b_height = 2; b_vblank = 1; b_coarse = 10; b_fine = 30;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;

    // R3: narrow window padded to 704; R7: no extension
    wait_fs();
    check(eff_hblank == 604, "R3 padded hblank", eff_hblank, 604);
    check(eff_vblank == 1412, "R7 normal vblank", eff_vblank, 1412);
    wait_fs();

    // R11: switch context and mode mid-frame; current frame unchanged
    repeat (100) @(negedge clk);
    ctx_sel = 1'b1; bin_mode = 2'b10;
    repeat (10) @(negedge clk);
    check(eff_hblank == 604, "R11 hblank held mid-frame", eff_hblank, 604);
    check(eff_vblank == 1412, "R11 vblank held mid-frame", eff_vblank, 1412);

    // R10: context B now applies; R2 bin-4 floor; R8 extension
    wait_fs();
    check(eff_hblank == 91, "R10/R2 context B bin4 floor", eff_hblank, 91);
    check(eff_vblank == 7544, "R8 extended vblank", eff_vblank, 7544);
    check(b_vblank == 1, "R9 register untouched", b_vblank, 1);
    wait_fs();

    // R2 bin-2 floor; R8 extension by fine term alone
    ctx_sel = 1'b0; bin_mode = 2'b01;
    a_width = 650; a_hblank = 65; a_height = 2; a_vblank = 3; a_coarse = 3; a_fine = 5;
    wait_fs();
    check(eff_hblank == 71, "R2 bin2 floor", eff_hblank, 71);
    check(eff_vblank == 2172, "R8 fine pushes extension", eff_vblank, 2172);

    // R7: long value equals normal value, normal kept
    a_fine = 0;
    wait_fs();
    check(eff_vblank == 2167, "R7 tie keeps normal", eff_vblank, 2167);

    // R2: programmed value above floor used as given
    a_hblank = 200;
    wait_fs();
    check(eff_hblank == 200, "R2 above floor", eff_hblank, 200);
    wait_fs();

    done = 1;
    finish_run();
  end

endmodule